// File: doc/BRIEF.md
# Four-Pixel Triggered Hit Buffer

This block is the digital logic shared by a 2x2 group of pixels. Each pixel delivers a discriminator pulse. The block measures how many clock cycles each pulse stays high, which is the time over threshold (ToT). Hits that occur together are gathered into one regional event. The event sits in one of a small number of local storage slots while its own latency counter runs. If a level-1 trigger arrives in the cycle that the counter equals the programmed latency, the event is kept for readout. Otherwise the event is dropped inside the region and never reaches the column bus.

A hit is "big" once its pulse has been high for more than `SMALL_MAX` cycles. The first big hit with no open event allocates a slot, and that allocation is also signalled to the neighbouring regions. A short ("small") hit gets no timestamp of its own. It is filed in whatever event is open when it ends. That event may have been opened by a big hit in this region, or by a neighbour's big-hit pulse that arrives while the small hit is still pending. In this way a late small hit takes the time of the large hit beside it.

Events that have been triggered wait in trigger order. While the region has such an event it raises a read request. When it holds the column token, it places the oldest triggered event on the bus for one cycle per event. The token passes downstream only when the region has nothing left to read.

Top module: `quad_hit_buffer`

## Requirements
- R1: A hit's ToT code is the number of consecutive clock cycles its discriminator was sampled high, saturating at 14. In a stored event, pixel p occupies `bus_tot[4p+3:4p]`, and a pixel with no hit in that event reads code 15.
- R2: A hit high for at most `SMALL_MAX` (default 2) cycles is stored as code 0, but only if an event is open when it ends. Such a hit never asserts `nbr_big_out`, and a small hit that ends with no open event is lost.
- R3: In the cycle where a pixel is sampled high for the (`SMALL_MAX`+1)-th consecutive time, `nbr_big_out` is high. If no event is open in that cycle, the lowest-numbered free slot is allocated.
- R4: If `nbr_big_in` is high while no event is open and any pixel is high or still being measured, a slot is allocated for those pending hits.
- R5: An open event collects every hit that ends while it is open. It closes at the first clock edge where all discriminator inputs are low.
- R6: A slot's latency counter reads 0 in the cycle after allocation and rises by one per cycle. The trigger matches the slot only in the cycle where the counter equals `latency`; a trigger one cycle early or late does not match.
- R7: A slot whose counter reaches `latency` without a trigger is freed and its event is never read out.
- R8: If a slot is needed while all `NSLOT` (default 5) slots are busy, `overflow` is high for that cycle and the hit is lost.
- R9: `read_req` is high while triggered events wait. With `token_in` high, `bus_valid` is high, `bus_tot` carries the oldest-triggered event (one event per cycle), and `token_out` is low. `token_out` equals `token_in` when nothing is waiting.
- R10: A synchronous reset frees every slot, drops waiting events and closes any open event.
- R11: A trigger that matches no slot produces no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 40 MHz-class bunch clock |
| rst | input | 1 | Synchronous reset, active high |
| latency | input | 8 | Programmed trigger latency in cycles |
| trigger | input | 1 | Level-1 trigger pulse |
| disc | input | 4 | Discriminator outputs, one bit per pixel |
| nbr_big_in | input | 1 | Big-hit pulse from a neighbouring region |
| nbr_big_out | output | 1 | Big-hit pulse to neighbouring regions |
| overflow | output | 1 | Hit lost because every slot is busy |
| token_in | input | 1 | Column read token from upstream |
| token_out | output | 1 | Column read token to downstream |
| read_req | output | 1 | Triggered data waiting |
| bus_valid | output | 1 | Region drives the column bus this cycle |
| bus_tot | output | 16 | ToT codes of the event on the bus, 4 bits per pixel |

## Verification
The bench places triggers exactly on, one cycle before and one cycle after the latency match. A counter that starts at the wrong value or compares one cycle off would store the wrong events or drop the right ones. It lets an older event expire so that a newer event reuses the lowest slot, and it then checks that readout follows trigger order and not slot number. It feeds a sixth event while five slots are busy and checks the loss cycle. It also covers a lone small hit and a small hit attached through the neighbour pulse. A design that timestamped small hits itself, or lost them, would show an extra event or a missing code 0.

// File: rtl/qhb_pkg.sv
package qhb_pkg;
  localparam int TOT_W = 4;
  localparam logic [TOT_W-1:0] CODE_NONE  = 4'hF;
  localparam logic [TOT_W-1:0] CODE_SMALL = 4'h0;
  localparam logic [TOT_W-1:0] TOT_SAT    = 4'd14;

  // one more high cycle, held at the saturation value
  function automatic logic [TOT_W-1:0] tot_step(input logic [TOT_W-1:0] c);
    return (c >= TOT_SAT) ? TOT_SAT : c + 1'b1;
  endfunction

  // stored code for a finished pulse of length len
  function automatic logic [TOT_W-1:0] tot_code(input logic [TOT_W-1:0] len,
                                                input int small_max);
    return (int'(len) <= small_max) ? CODE_SMALL : len;
  endfunction
endpackage

// File: rtl/qhb_pix_tot.sv
module qhb_pix_tot import qhb_pkg::*; #(
  parameter int SMALL_MAX = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disc,
  output logic             active,
  output logic             big_now,
  output logic             done,
  output logic [TOT_W-1:0] len
);
  logic [TOT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (disc) begin
      active <= 1'b1;
      cnt    <= active ? tot_step(cnt) : TOT_W'(1);
    end else begin
      active <= 1'b0;
    end
  end

  // the pulse turns big at this edge
  assign big_now = disc & active & (cnt == TOT_W'(SMALL_MAX));
  // the pulse ended; len holds its measured length
  assign done    = active & ~disc;
  assign len     = cnt;
endmodule

// File: rtl/qhb_lat_slot.sv
module qhb_lat_slot #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             release_i,
  input  logic             trigger,
  input  logic [LAT_W-1:0] latency,
  output logic             busy,
  output logic             trig_hit,
  output logic             expire
);
  logic             held;
  logic [LAT_W-1:0] age;
  logic             match;

  assign match    = busy & ~held & (age == latency);
  assign trig_hit = match & trigger;
  assign expire   = match & ~trigger;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      held <= 1'b0;
      age  <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      held <= 1'b0;
      age  <= '0;
    end else if (busy && !held) begin
      if (match) begin
        if (trigger) held <= 1'b1;
        else         busy <= 1'b0;
      end else begin
        age <= age + 1'b1;
      end
    end else if (busy && held && release_i) begin
      busy <= 1'b0;
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/qhb_order_fifo.sv
module qhb_order_fifo #(
  parameter int DEPTH = 5,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_idx,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nonempty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  q [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) begin
        q[wr_ptr] <= push_idx;
        wr_ptr    <= ptr_inc(wr_ptr);
      end
      if (pop) rd_ptr <= ptr_inc(rd_ptr);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  assign head     = q[rd_ptr];
  assign nonempty = (fill != '0);
endmodule

// File: rtl/quad_hit_buffer.sv
module quad_hit_buffer import qhb_pkg::*; #(
  parameter int NPIX      = 4,
  parameter int NSLOT     = 5,
  parameter int LAT_W     = 8,
  parameter int SMALL_MAX = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LAT_W-1:0]      latency,
  input  logic                  trigger,
  input  logic [NPIX-1:0]       disc,
  input  logic                  nbr_big_in,
  output logic                  nbr_big_out,
  output logic                  overflow,
  input  logic                  token_in,
  output logic                  token_out,
  output logic                  read_req,
  output logic                  bus_valid,
  output logic [NPIX*TOT_W-1:0] bus_tot
);
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  // pixel side
  logic [NPIX-1:0]  pix_active, pix_big, pix_done;
  logic [TOT_W-1:0] pix_len  [NPIX];
  logic [TOT_W-1:0] pix_code [NPIX];

  // slot side
  logic [NSLOT-1:0] busy_vec, trig_vec, exp_vec, alloc_vec, rel_vec;

  // event control, named for the checker
  logic              open_q;
  logic [SLOT_W-1:0] open_idx;
  logic              alloc_req, alloc_ok, free_any, open_kill;
  logic [SLOT_W-1:0] free_sel, trig_idx, tgt_idx, head_idx;
  logic              tgt_valid, pend_any, pop;

  logic [TOT_W-1:0] tot_mem [NSLOT][NPIX];

  genvar gp, gs;
  generate
    for (gp = 0; gp < NPIX; gp++) begin : g_pix
      qhb_pix_tot #(.SMALL_MAX(SMALL_MAX)) u_pix (
        .clk(clk), .rst(rst), .disc(disc[gp]),
        .active(pix_active[gp]), .big_now(pix_big[gp]),
        .done(pix_done[gp]), .len(pix_len[gp])
      );
      assign pix_code[gp] = tot_code(pix_len[gp], SMALL_MAX);
    end

    for (gs = 0; gs < NSLOT; gs++) begin : g_slot
      assign alloc_vec[gs] = alloc_ok & (free_sel == SLOT_W'(gs));
      assign rel_vec[gs]   = pop & (head_idx == SLOT_W'(gs));
      qhb_lat_slot #(.LAT_W(LAT_W)) u_slot (
        .clk(clk), .rst(rst), .alloc(alloc_vec[gs]),
        .release_i(rel_vec[gs]), .trigger(trigger), .latency(latency),
        .busy(busy_vec[gs]), .trig_hit(trig_vec[gs]), .expire(exp_vec[gs])
      );
    end
  endgenerate

  // lowest-numbered free slot
  always_comb begin
    free_sel = '0;
    free_any = 1'b0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (!busy_vec[s]) begin
        free_sel = SLOT_W'(s);
        free_any = 1'b1;
      end
    end
  end

  // slot whose trigger matched this cycle
  always_comb begin
    trig_idx = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (trig_vec[s]) trig_idx = SLOT_W'(s);
    end
  end

  assign pend_any    = (|disc) | (|pix_active);
  assign nbr_big_out = |pix_big;
  assign alloc_req   = ~open_q & ((|pix_big) | (nbr_big_in & pend_any));
  assign alloc_ok    = alloc_req & free_any;
  assign overflow    = alloc_req & ~free_any;
  assign open_kill   = open_q & (exp_vec[open_idx] | trig_vec[open_idx]);
  assign tgt_valid   = (open_q & ~open_kill) | alloc_ok;
  assign tgt_idx     = open_q ? open_idx : free_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      open_idx <= '0;
    end else begin
      open_q <= ((open_q & ~open_kill) | alloc_ok) & (|disc);
      if (alloc_ok) open_idx <= free_sel;
    end
  end

  // event storage: cleared on allocation, written as pulses end
  always_ff @(posedge clk) begin
    for (int s = 0; s < NSLOT; s++) begin
      for (int p = 0; p < NPIX; p++) begin
        if (rst) begin
          tot_mem[s][p] <= CODE_NONE;
        end else begin
          if (alloc_vec[s]) tot_mem[s][p] <= CODE_NONE;
          if (tgt_valid && pix_done[p] && tgt_idx == SLOT_W'(s))
            tot_mem[s][p] <= pix_code[p];
        end
      end
    end
  end

  qhb_order_fifo #(.DEPTH(NSLOT), .W(SLOT_W)) u_order (
    .clk(clk), .rst(rst), .push(|trig_vec), .push_idx(trig_idx),
    .pop(pop), .head(head_idx), .nonempty(read_req)
  );

  assign bus_valid = token_in & read_req;
  assign pop       = bus_valid;
  assign token_out = token_in & ~read_req;

  always_comb begin
    for (int p = 0; p < NPIX; p++)
      bus_tot[p*TOT_W +: TOT_W] = bus_valid ? tot_mem[head_idx][p] : '0;
  end
endmodule

// File: rtl/qhb_chk.sv
module qhb_chk #(
  parameter int NPIX  = 4,
  parameter int NSLOT = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [NPIX-1:0]  disc,
  input logic             token_in,
  input logic             token_out,
  input logic             read_req,
  input logic             bus_valid,
  input logic             overflow,
  input logic             alloc_ok,
  input logic             open_q,
  input logic [NSLOT-1:0] busy_vec,
  input logic [NSLOT-1:0] alloc_vec,
  input logic [NSLOT-1:0] trig_vec
);
  p_alloc_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc_vec));
  p_alloc_from_free_r3: assert property (@(posedge clk) disable iff (rst)
    alloc_ok |-> !(&busy_vec));
  p_close_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (disc == '0) |=> !open_q);
  p_trig_single_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig_vec));
  p_overflow_full_r8: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (&busy_vec) && !alloc_ok);
  p_req_after_trig_r9: assert property (@(posedge clk) disable iff (rst)
    (|trig_vec) |=> read_req);
  p_token_held_r9: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> token_in && !token_out);
endmodule

bind quad_hit_buffer qhb_chk #(.NPIX(NPIX), .NSLOT(NSLOT)) u_chk (.*);

// File: tb/tb_quad_hit_buffer.sv
module tb_quad_hit_buffer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, trigger, nbr_big_in, token_in;
  logic [7:0]  latency;
  logic [3:0]  disc;
  logic        nbr_big_out, overflow, token_out, read_req, bus_valid;
  logic [15:0] bus_tot;

  quad_hit_buffer dut (
    .clk(clk), .rst(rst), .latency(latency), .trigger(trigger), .disc(disc),
    .nbr_big_in(nbr_big_in), .nbr_big_out(nbr_big_out), .overflow(overflow),
    .token_in(token_in), .token_out(token_out), .read_req(read_req),
    .bus_valid(bus_valid), .bus_tot(bus_tot)
  );

  int checks = 0, fails = 0;
  logic [3:0] s_disc [256];
  bit s_trig [256];
  bit s_nbr  [256];
  int first_nbr, ovf_cnt, ovf_cyc;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_sched();
    for (int i = 0; i < 256; i++) begin
      s_disc[i] = '0; s_trig[i] = 1'b0; s_nbr[i] = 1'b0;
    end
    first_nbr = -1; ovf_cnt = 0; ovf_cyc = -1;
  endtask

  task automatic add_pulse(input int pix, input int start, input int len);
    for (int i = start; i < start + len; i++) s_disc[i][pix] = 1'b1;
  endtask

  task automatic play(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      disc = s_disc[c]; trigger = s_trig[c]; nbr_big_in = s_nbr[c];
      #1;
      if (nbr_big_out && first_nbr < 0) first_nbr = c;
      if (overflow) begin ovf_cnt++; ovf_cyc = c; end
    end
    @(negedge clk);
    disc = '0; trigger = 1'b0; nbr_big_in = 1'b0;
    #1;
  endtask

  task automatic read_expect(input logic [15:0] exp, input string req);
    @(negedge clk);
    token_in = 1'b1;
    #1;
    chk(bus_valid === 1'b1, {req, " bus_valid"}, 32'(bus_valid), 1);
    chk(bus_tot === exp, {req, " bus_tot"}, 32'(bus_tot), 32'(exp));
    chk(token_out === 1'b0, "R9 token held", 32'(token_out), 0);
    @(negedge clk);
    token_in = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    token_in = 1'b1;
    #1;
    chk(read_req === 1'b0, "R10 read_req after reset", 32'(read_req), 0);
    chk(bus_valid === 1'b0, "R10 bus_valid after reset", 32'(bus_valid), 0);
    chk(token_out === 1'b1, "R9 token passes when idle", 32'(token_out), 1);
    chk(overflow === 1'b0, "R10 overflow after reset", 32'(overflow), 0);
    token_in = 1'b0;
  endtask

  task automatic t_single();
    latency = 8'd12; clear_sched();
    add_pulse(0, 0, 6); add_pulse(1, 1, 4);
    s_trig[15] = 1'b1;
    play(18);
    chk(first_nbr == 2, "R3 big pulse cycle", 32'(first_nbr), 2);
    chk(read_req === 1'b1, "R6 trigger on match", 32'(read_req), 1);
    read_expect(16'hFF46, "R1 R5 single event");
    chk(read_req === 1'b0, "R9 drained", 32'(read_req), 0);
  endtask

  task automatic t_small_join();
    latency = 8'd30; clear_sched();
    add_pulse(0, 0, 8); add_pulse(3, 1, 20); add_pulse(2, 3, 2);
    s_trig[33] = 1'b1;
    play(36);
    read_expect(16'hE0F8, "R1 R2 saturate and small join");
    chk(read_req === 1'b0, "R5 one event only", 32'(read_req), 0);
  endtask

  task automatic t_small_alone();
    latency = 8'd10; clear_sched();
    add_pulse(1, 0, 2);
    s_trig[13] = 1'b1;
    play(16);
    chk(first_nbr == -1, "R2 small never big", 32'(first_nbr), 32'hFFFFFFFF);
    chk(read_req === 1'b0, "R2 R11 lone small lost", 32'(read_req), 0);
  endtask

  task automatic t_nbr();
    latency = 8'd12; clear_sched();
    add_pulse(2, 0, 2);
    s_nbr[1] = 1'b1;
    s_trig[14] = 1'b1;
    play(17);
    chk(first_nbr == -1, "R2 no own big", 32'(first_nbr), 32'hFFFFFFFF);
    read_expect(16'hF0FF, "R4 neighbour attach");
  endtask

  task automatic t_trig_miss();
    latency = 8'd12; clear_sched();
    add_pulse(0, 0, 3);
    s_trig[14] = 1'b1; s_trig[16] = 1'b1;
    play(20);
    chk(read_req === 1'b0, "R6 R7 off-by-one triggers", 32'(read_req), 0);
  endtask

  task automatic t_order();
    latency = 8'd20; clear_sched();
    add_pulse(0, 0, 3);   // slot 0, expires
    add_pulse(1, 5, 4);   // slot 1
    add_pulse(2, 30, 5);  // reuses slot 0
    s_trig[28] = 1'b1; s_trig[53] = 1'b1;
    play(56);
    chk(ovf_cnt == 0, "R8 no overflow", 32'(ovf_cnt), 0);
    read_expect(16'hFF4F, "R7 R9 older trigger first");
    read_expect(16'hF5FF, "R9 second event");
    chk(read_req === 1'b0, "R7 expired never read", 32'(read_req), 0);
  endtask

  task automatic t_ovf();
    latency = 8'd80; clear_sched();
    for (int i = 0; i < 6; i++) begin
      add_pulse(0, 10 * i, 3 + i);
      s_trig[10 * i + 83] = 1'b1;
    end
    play(136);
    chk(ovf_cnt == 1, "R8 overflow count", 32'(ovf_cnt), 1);
    chk(ovf_cyc == 52, "R8 overflow cycle", 32'(ovf_cyc), 52);
    for (int i = 0; i < 5; i++)
      read_expect(16'hFFF0 | 16'(3 + i), "R8 R9 stored event");
    chk(read_req === 1'b0, "R8 R11 lost event absent", 32'(read_req), 0);
  endtask

  task automatic t_reset2();
    latency = 8'd10; clear_sched();
    add_pulse(0, 0, 3);
    s_trig[13] = 1'b1;
    play(16);
    chk(read_req === 1'b1, "R6 event waiting", 32'(read_req), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    token_in = 1'b1;
    #1;
    chk(read_req === 1'b0, "R10 reset drops events", 32'(read_req), 0);
    chk(bus_valid === 1'b0, "R10 bus idle after reset", 32'(bus_valid), 0);
    token_in = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; trigger = 1'b0; nbr_big_in = 1'b0; token_in = 1'b0;
    disc = '0; latency = 8'd10;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_small_join();
    t_small_alone();
    t_nbr();
    t_trig_miss();
    t_order();
    t_ovf();
    t_reset2();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule